// File: doc/BRIEF.md
# Dual-Port RAM Access Sequencer

This block runs the fixed, repeating schedule of byte transfers between a bank of serial time-division streams and an external dual-port memory with an 8-bit data port. It is clocked by the fast parallel-port clock. Each channel slot holds a group of twelve memory writes, an idle gap, a group of twelve memory reads and a second idle gap. The idle gap lasts four clocks in the fast modes and eight clocks in the slow modes. For every clock the block reports which access is under way and which serial stream it belongs to. It also drives the three memory control lines. The address generator elsewhere in the chip consumes the access type and the stream index.

The operating mode comes in as a 3-bit code and is captured only while reset is held. A frame pulse realigns the schedule so that the first write of a slot follows the boundary at once. At the end of each read cycle the block captures the byte on the read bus and the serial output-enable bit that is stored beside it. It presents both, tagged with their stream, for the serial side.

Top module: `dpram_sequencer`

## Requirements
- R1: `mode_code` is captured on every clock edge with `rst` high and is ignored while `rst` is low. A code change after reset leaves the schedule unchanged.
- R2: After reset, and until the first clock edge that samples `frame_sync` high, the access type is idle (`acc_kind` = 2'b00), and `strobe_n`, `wr_pulse_n` and `rw_level` are all high.
- R3: A clock edge that samples `frame_sync` high puts the sequencer at slot position 0, the first write of a group, with the slot count cleared to 0. This applies whatever the current position is.
- R4: A slot consists of 12 write cycles (`acc_kind` = 2'b01), then G idle cycles, then 12 read cycles (`acc_kind` = 2'b10), then G idle cycles. G is 8 for codes 000 and 001 and 4 for every other code, so a slot is 40 or 32 clocks.
- R5: For code 010 and for the unused codes 101, 110 and 111, the writes carry streams 0 to 11 in order and the reads carry streams 12 to 23 in order, in every slot.
- R6: For codes 000 and 001, both groups carry streams 0 to 11 in slots with an even count and streams 12 to 23 in slots with an odd count. The count runs from 0 at the frame pulse.
- R7: For codes 011 and 100, each group first carries streams 16 to 23. It then carries the four streams 4q to 4q+3, where q is the slot count modulo 4.
- R8: In a read cycle `strobe_n` and `rw_level` are low for the whole cycle and `wr_pulse_n` is high.
- R9: In a write cycle `rw_level` is high. `wr_pulse_n` and `strobe_n` are high in the first half of the clock period (clock high) and low in the second half (clock low).
- R10: In an idle cycle `strobe_n`, `wr_pulse_n` and `rw_level` are all high.
- R11: The clock edge that ends a read cycle captures `rd_data` and `oe_bit`. In the following cycle `cap_valid` is high, and `cap_data`, `cap_oe` and `cap_stream` hold the captured values and that cycle's stream. `cap_valid` is low after every other cycle.
- R12: After the last idle cycle of a slot the next slot starts at position 0 without any frame pulse, and the slot count increments modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-port clock |
| rst | input | 1 | Synchronous active-high reset; the mode is captured while it is high |
| mode_code | input | 3 | Operating mode code |
| frame_sync | input | 1 | Frame boundary pulse |
| rd_data | input | 8 | Byte read from the memory |
| oe_bit | input | 1 | Output-enable bit stored beside the read byte |
| acc_kind | output | 2 | Access type: 00 idle, 01 write, 10 read |
| acc_stream | output | 5 | Stream index of the current access |
| wr_pulse_n | output | 1 | Write pulse, active low in the second half of each write cycle |
| rw_level | output | 1 | High for write and idle, low for read |
| strobe_n | output | 1 | Memory chip enable, active low |
| cap_valid | output | 1 | Captured read data valid |
| cap_data | output | 8 | Captured read byte |
| cap_oe | output | 1 | Captured output-enable bit |
| cap_stream | output | 5 | Stream of the captured byte |

## Verification
`acc_kind` and `acc_stream` follow the slot position with no delay. The first write is therefore visible in the clock period that starts at the edge that sampled the frame pulse, and the bench checks them 1 ns after each rising edge. The control lines are checked twice per period: at the first-half point, and 0.5 ns after the falling edge where the half-cycle write pulse must be low. Capture results are due one edge after the read cycle. The bench compares them with the byte it drove during that read cycle, using the values it recorded at the edge.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int NUM_STREAMS = 24;
    localparam int GROUP       = 12;
    localparam int HI_COUNT    = 8;
    localparam int LO_PER_GRP  = 4;
    localparam int GAP_SLOW    = 8;
    localparam int GAP_FAST    = 4;
    localparam int MODE_W      = 3;
    localparam int DATA_W      = 8;
    localparam int STRM_W      = $clog2(NUM_STREAMS);
    localparam int POS_W       = $clog2(2 * GROUP + 2 * GAP_SLOW);
    localparam int TURN_W      = 2;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'b00,
        ACC_WR   = 2'b01,
        ACC_RD   = 2'b10
    } acc_e;

    typedef enum logic [1:0] {
        CLS_SPLIT  = 2'b00,
        CLS_HALVES = 2'b01,
        CLS_MIXED  = 2'b10
    } cls_e;

    typedef struct packed {
        acc_e              kind;
        logic [STRM_W-1:0] stream;
    } access_t;

    function automatic cls_e class_of(logic [MODE_W-1:0] code);
        case (code)
            3'b000, 3'b001: return CLS_HALVES;
            3'b011, 3'b100: return CLS_MIXED;
            default:        return CLS_SPLIT;
        endcase
    endfunction

    function automatic logic [POS_W-1:0] gap_of(cls_e c);
        return (c == CLS_HALVES) ? POS_W'(GAP_SLOW) : POS_W'(GAP_FAST);
    endfunction

    function automatic logic [POS_W-1:0] slot_last(cls_e c);
        return POS_W'(2 * GROUP - 1) + (gap_of(c) << 1);
    endfunction

endpackage

// File: rtl/dps_slot_timer.sv
module dps_slot_timer
    import dps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   mode_code,
    input  logic                frame_sync,
    output cls_e                cls,
    output logic                synced,
    output logic [POS_W-1:0]    pos,
    output logic [TURN_W-1:0]   turn
);

    cls_e              cls_q;
    logic [POS_W-1:0]  last;

    assign last = slot_last(cls_q);
    assign cls  = cls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q  <= class_of(mode_code);
            synced <= 1'b0;
            pos    <= '0;
            turn   <= '0;
        end else if (frame_sync) begin
            synced <= 1'b1;
            pos    <= '0;
            turn   <= '0;
        end else if (synced) begin
            if (pos == last) begin
                pos  <= '0;
                turn <= turn + 1'b1;
            end else begin
                pos  <= pos + 1'b1;
            end
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cls_q)); // R1
    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (pos == '0) && (turn == '0) && synced); // R3
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (synced && !frame_sync && pos == last) |=> (pos == '0) && (turn == $past(turn) + 1'b1)); // R12
    AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
        pos <= last); // R4

endmodule

// File: rtl/dps_access_map.sv
module dps_access_map
    import dps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cls_e                cls,
    input  logic                synced,
    input  logic [POS_W-1:0]    pos,
    input  logic [TURN_W-1:0]   turn,
    output access_t             acc
);

    logic [POS_W-1:0] rd_start;
    logic [POS_W-1:0] idx;
    logic             in_wr;
    logic             in_rd;

    assign rd_start = POS_W'(GROUP) + gap_of(cls);
    assign in_wr    = synced && (pos < POS_W'(GROUP));
    assign in_rd    = synced && (pos >= rd_start) && (pos < rd_start + POS_W'(GROUP));
    assign idx      = in_rd ? (pos - rd_start) : pos;

    always_comb begin
        acc.kind   = ACC_IDLE;
        acc.stream = '0;
        if (in_wr || in_rd) begin
            acc.kind = in_wr ? ACC_WR : ACC_RD;
            case (cls)
                CLS_HALVES:
                    acc.stream = STRM_W'(idx) + (turn[0] ? STRM_W'(GROUP) : STRM_W'(0));
                CLS_MIXED:
                    if (idx < POS_W'(HI_COUNT))
                        acc.stream = STRM_W'(NUM_STREAMS - HI_COUNT) + STRM_W'(idx);
                    else
                        acc.stream = STRM_W'({turn, 2'b00}) + STRM_W'(idx - POS_W'(HI_COUNT));
                default:
                    acc.stream = STRM_W'(idx) + (in_rd ? STRM_W'(GROUP) : STRM_W'(0));
            endcase
        end
    end

    AST_STREAM_RANGE: assert property (@(posedge clk) disable iff (rst)
        acc.kind != ACC_IDLE |-> acc.stream < STRM_W'(NUM_STREAMS)); // R5
    AST_IDLE_UNSYNCED: assert property (@(posedge clk) disable iff (rst)
        !synced |-> acc.kind == ACC_IDLE); // R2
    AST_GROUP_START: assert property (@(posedge clk) disable iff (rst)
        (synced && pos == '0) |-> acc.kind == ACC_WR); // R4

endmodule

// File: rtl/dps_pin_drive.sv
module dps_pin_drive
    import dps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_e kind,
    output logic wr_pulse_n,
    output logic rw_level,
    output logic strobe_n
);

    logic rise_tog;
    logic fall_tog;
    logic late_half;

    always_ff @(posedge clk) begin
        if (rst) rise_tog <= 1'b0;
        else     rise_tog <= ~rise_tog;
    end

    always_ff @(negedge clk) begin
        fall_tog <= rise_tog;
    end

    assign late_half  = (rise_tog == fall_tog);
    assign rw_level   = (kind != ACC_RD);
    assign wr_pulse_n = !((kind == ACC_WR) && late_half);
    assign strobe_n   = !((kind == ACC_RD) || ((kind == ACC_WR) && late_half));

    AST_RD_LINES: assert property (@(posedge clk) disable iff (rst)
        kind == ACC_RD |-> !strobe_n && !rw_level && wr_pulse_n); // R8
    AST_WR_LATE_LOW: assert property (@(posedge clk) disable iff (rst)
        kind == ACC_WR |-> !strobe_n && !wr_pulse_n && rw_level); // R9
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        kind == ACC_IDLE |-> strobe_n && wr_pulse_n && rw_level); // R10

endmodule

// File: rtl/dpram_sequencer.sv
module dpram_sequencer
    import dps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   mode_code,
    input  logic                frame_sync,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                oe_bit,
    output logic [1:0]          acc_kind,
    output logic [STRM_W-1:0]   acc_stream,
    output logic                wr_pulse_n,
    output logic                rw_level,
    output logic                strobe_n,
    output logic                cap_valid,
    output logic [DATA_W-1:0]   cap_data,
    output logic                cap_oe,
    output logic [STRM_W-1:0]   cap_stream
);

    cls_e               cls;
    logic               synced;
    logic [POS_W-1:0]   pos;
    logic [TURN_W-1:0]  turn;
    access_t            acc;

    dps_slot_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .mode_code  (mode_code),
        .frame_sync (frame_sync),
        .cls        (cls),
        .synced     (synced),
        .pos        (pos),
        .turn       (turn)
    );

    dps_access_map u_map (
        .clk    (clk),
        .rst    (rst),
        .cls    (cls),
        .synced (synced),
        .pos    (pos),
        .turn   (turn),
        .acc    (acc)
    );

    dps_pin_drive u_pins (
        .clk        (clk),
        .rst        (rst),
        .kind       (acc.kind),
        .wr_pulse_n (wr_pulse_n),
        .rw_level   (rw_level),
        .strobe_n   (strobe_n)
    );

    assign acc_kind   = acc.kind;
    assign acc_stream = acc.stream;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid  <= 1'b0;
            cap_data   <= '0;
            cap_oe     <= 1'b0;
            cap_stream <= '0;
        end else begin
            cap_valid <= (acc.kind == ACC_RD);
            if (acc.kind == ACC_RD) begin
                cap_data   <= rd_data;
                cap_oe     <= oe_bit;
                cap_stream <= acc.stream;
            end
        end
    end

    AST_CAP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        (acc.kind == ACC_RD) |=> cap_valid && (cap_data == $past(rd_data)) && (cap_oe == $past(oe_bit))); // R11
    AST_CAP_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        (acc.kind != ACC_RD) |=> !cap_valid); // R11

endmodule

// File: tb/sim_dpram_sequencer.sv
`timescale 1ns/100ps
module sim_dpram_sequencer;
    import dps_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_code = 3'b000;
    logic        frame_sync = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        oe_bit = 1'b0;
    logic [1:0]  acc_kind;
    logic [4:0]  acc_stream;
    logic        wr_pulse_n, rw_level, strobe_n;
    logic        cap_valid, cap_oe;
    logic [7:0]  cap_data;
    logic [4:0]  cap_stream;

    always #2.5 clk = ~clk;

    dpram_sequencer u0 (
        .clk(clk), .rst(rst), .mode_code(mode_code), .frame_sync(frame_sync),
        .rd_data(rd_data), .oe_bit(oe_bit), .acc_kind(acc_kind), .acc_stream(acc_stream),
        .wr_pulse_n(wr_pulse_n), .rw_level(rw_level), .strobe_n(strobe_n),
        .cap_valid(cap_valid), .cap_data(cap_data), .cap_oe(cap_oe), .cap_stream(cap_stream)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit r1_run = 1'b0;

    // bench model state
    int  m_gap = 4;
    int  m_cls = 0;      // 0 split, 1 halves, 2 mixed
    bit  m_sync = 0;
    int  m_pos = 0;
    int  m_turn = 0;
    bit  e_cv = 0;
    logic [7:0] e_cd = 0;
    bit  e_co = 0;
    int  e_cs = 0;

    function automatic int cls_for(logic [2:0] c);
        if (c == 3'd0 || c == 3'd1) return 1;
        if (c == 3'd3 || c == 3'd4) return 2;
        return 0;
    endfunction

    // kind: 0 idle, 1 write, 2 read
    function automatic int want_kind(int p);
        if (!m_sync) return 0;
        if (p < 12) return 1;
        if (p >= 12 + m_gap && p < 24 + m_gap) return 2;
        return 0;
    endfunction

    function automatic int want_stream(int p);
        int k = want_kind(p);
        int i = (k == 2) ? p - 12 - m_gap : p;
        if (k == 0) return 0;
        if (m_cls == 1) return i + ((m_turn % 2) * 12);
        if (m_cls == 2) return (i < 8) ? 16 + i : (m_turn * 4) + (i - 8);
        return (k == 2) ? i + 12 : i;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d pos=%0d turn=%0d t=%0t", req, act, exp, m_pos, m_turn, $time);
        end
    endtask

    task automatic step(logic fs_next);
        int k, s;
        string kt, st, pt;
        @(posedge clk);
        k = want_kind(m_pos);
        s = want_stream(m_pos);
        if (rst) begin
            e_cv = 0;
            m_cls = cls_for(mode_code);
            m_gap = (m_cls == 1) ? 8 : 4;
            m_sync = 0; m_pos = 0; m_turn = 0;
        end else begin
            e_cv = (k == 2);
            if (k == 2) begin e_cd = rd_data; e_co = oe_bit; e_cs = s; end
            if (frame_sync) begin
                m_sync = 1; m_pos = 0; m_turn = 0;
            end else if (m_sync) begin
                if (m_pos == 23 + 2 * m_gap) begin m_pos = 0; m_turn = (m_turn + 1) % 4; end
                else m_pos++;
            end
        end
        #1;
        k = want_kind(m_pos);
        s = want_stream(m_pos);
        kt = r1_run ? "R1" : (!m_sync ? "R2" : (m_pos == 0 ? (m_turn != 0 ? "R12" : "R3") : "R4"));
        st = (m_cls == 1) ? "R6" : (m_cls == 2) ? "R7" : "R5";
        pt = (k == 2) ? "R8" : (k == 1) ? "R9" : "R10";
        check(kt, int'(acc_kind), k);
        if (k != 0) check(st, int'(acc_stream), s);
        check(pt, {29'd0, strobe_n, wr_pulse_n, rw_level}, (k == 2) ? 3'b010 : 3'b111);
        check("R11", int'(cap_valid), int'(e_cv));
        if (e_cv) begin
            check("R11", int'(cap_data), int'(e_cd));
            check("R11", int'(cap_oe), int'(e_co));
            check("R11", int'(cap_stream), e_cs);
        end
        frame_sync = fs_next;
        rd_data = 8'($urandom);
        oe_bit = 1'($urandom);
        #2;
        check(pt, {29'd0, strobe_n, wr_pulse_n, rw_level}, (k == 2) ? 3'b010 : (k == 1) ? 3'b001 : 3'b111);
    endtask

    task automatic run_mode(logic [2:0] code, logic [2:0] late_code, int n, bit mid_pulse);
        rst = 1'b1; mode_code = code; r1_run = 0;
        repeat (3) step(1'b0);
        rst = 1'b0;
        mode_code = late_code;
        r1_run = (late_code != code);
        repeat (4) step(1'b0);       // R2: idle until the first frame pulse
        step(1'b1);
        for (int i = 0; i < n; i++) begin
            bit p = mid_pulse && (i == n / 2 + 7);
            step(p);                  // R3 realign mid-slot
        end
        step(1'b0);
    endtask

    initial begin
        int junk;
        junk = $urandom(32'h5EED);
        run_mode(3'b010, 3'b010, 80, 1'b1);
        run_mode(3'b000, 3'b000, 170, 1'b1);
        run_mode(3'b001, 3'b001, 90, 1'b0);
        run_mode(3'b011, 3'b011, 140, 1'b1);
        run_mode(3'b100, 3'b100, 135, 1'b0);
        run_mode(3'b110, 3'b110, 70, 1'b0);
        run_mode(3'b011, 3'b000, 140, 1'b0);   // R1: late code change ignored
        for (int r = 0; r < 6; r++) begin
            logic [2:0] c = 3'($urandom % 8);
            run_mode(c, 3'($urandom % 8), 60 + int'($urandom % 100), 1'($urandom));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule